// File: doc/BRIEF.md
# Adapter Interrupt Suppression Gate

This block sits between the adapter-interrupt sources and the pending-interrupt store. It keeps a suppression mode for each of eight interruption subclasses. An adapter request arrives with a type, a subclass and a flag that marks it as suppressible. The block either forwards the request as an I/O interrupt word or drops it.

Each subclass runs in one of two modes. In "all" mode every request passes. In "single" mode one suppressible request passes, and that request arms a blocking state for its subclass. Further suppressible requests on that subclass are then dropped until software writes the mode again. Requests that are not suppressible are always forwarded and never touch the state. A mode write with an unknown code is refused with an error pulse and changes nothing.

Top module: `adapter_irq_gate`

## Requirements
- R1: While rst_ni is low, and after it rises with no requests, both mode masks read 0x00 and irq_valid_o, suppressed_o and mode_err_o are low.
- R2: A mode write with code 0 ("all") clears both the single bit and the blocking bit of the addressed subclass.
- R3: A mode write with code 1 ("single") sets the single bit and clears the blocking bit of the addressed subclass.
- R4: A mode write with codes 2 or 3 pulses mode_err_o for one cycle and leaves both masks unchanged.
- R5: A suppressible request whose subclass has its blocking bit set is dropped. suppressed_o pulses and irq_valid_o stays low.
- R6: A forwarded request pulses irq_valid_o with irq_word_o = bit 31 set, the subclass in bits 29:27 and all other bits zero. irq_type_o carries the request type.
- R7: Forwarding a suppressible request of a subclass whose single bit is set sets that subclass's blocking bit.
- R8: A request without the suppressible flag is always forwarded and changes neither mask.
- R9: A request and a mode write in the same cycle: the request is judged on the masks as they stood before that cycle. If both address the same subclass, the mode write decides that subclass's blocking bit.
- R10: All outputs are registered and appear one cycle after the request. irq_valid_o and suppressed_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Mode write strobe |
| mode_class_i | input | 3 | Subclass addressed by the mode write |
| mode_code_i | input | 2 | Mode code: 0 all, 1 single, others invalid |
| inj_valid_i | input | 1 | Adapter request strobe |
| inj_type_i | input | 8 | Adapter request type |
| inj_class_i | input | 3 | Subclass of the adapter request |
| inj_supp_i | input | 1 | Request is suppressible |
| irq_valid_o | output | 1 | Interrupt word valid pulse |
| irq_word_o | output | 32 | Interrupt word toward the pending store |
| irq_type_o | output | 8 | Type of the forwarded request |
| suppressed_o | output | 1 | Request-dropped pulse |
| mode_err_o | output | 1 | Invalid mode code pulse |
| single_mask_o | output | 8 | Single-mode bit per subclass |
| noint_mask_o | output | 8 | Blocking bit per subclass |

## Verification
Every result is due exactly one rising edge after the cycle in which its request or mode write is presented. This covers the word, the type, the dropped pulse, the error pulse and both masks. The bench applies each stimulus on a falling edge and samples the outputs on the next falling edge, so each check falls half a cycle after the register that produces the result. Same-cycle collisions of a write and a request are placed in single vectors, so that the old-state decision and the new mask can both be seen in the same sampling cycle.

// File: rtl/aig_pkg.sv
package aig_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ALL    = 2'd0,
    MODE_SINGLE = 2'd1
  } mode_e;
endpackage

// File: rtl/aig_mode_regs.sv
module aig_mode_regs #(
  parameter int NUM_CLASS = 8,
  parameter int CLASS_W   = $clog2(NUM_CLASS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_i,
  input  logic [CLASS_W-1:0]         set_class_i,
  input  logic [aig_pkg::MODE_W-1:0] set_code_i,
  input  logic [NUM_CLASS-1:0]       arm_i,
  output logic [NUM_CLASS-1:0]       single_o,
  output logic [NUM_CLASS-1:0]       noint_o,
  output logic                       err_o
);
  import aig_pkg::*;

  logic code_ok;
  assign code_ok = (set_code_i == MODE_ALL) || (set_code_i == MODE_SINGLE);
  assign err_o   = set_i && !code_ok;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic wr;
    assign wr = set_i && code_ok && (set_class_i == CLASS_W'(c));

    // mode write outranks arming on the same subclass
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        single_o[c] <= 1'b0;
        noint_o[c]  <= 1'b0;
      end else if (wr) begin
        single_o[c] <= (set_code_i == MODE_SINGLE);
        noint_o[c]  <= 1'b0;
      end else if (arm_i[c]) begin
        noint_o[c]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aig_gate.sv
module aig_gate #(
  parameter int NUM_CLASS = 8,
  parameter int CLASS_W   = $clog2(NUM_CLASS),
  parameter int WORD_W    = 32,
  parameter int CLASS_LSB = 27,
  parameter int FLAG_BIT  = 31
) (
  input  logic                 inj_valid_i,
  input  logic [CLASS_W-1:0]   inj_class_i,
  input  logic                 inj_supp_i,
  input  logic [NUM_CLASS-1:0] single_i,
  input  logic [NUM_CLASS-1:0] noint_i,
  output logic                 fwd_o,
  output logic                 drop_o,
  output logic [NUM_CLASS-1:0] arm_o,
  output logic [WORD_W-1:0]    word_o
);
  assign drop_o = inj_valid_i && inj_supp_i && noint_i[inj_class_i];
  assign fwd_o  = inj_valid_i && !drop_o;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_arm
    assign arm_o[c] = fwd_o && inj_supp_i && single_i[c]
                      && (inj_class_i == CLASS_W'(c));
  end

  always_comb begin
    word_o = WORD_W'(inj_class_i) << CLASS_LSB;
    word_o[FLAG_BIT] = 1'b1;
  end
endmodule

// File: rtl/adapter_irq_gate.sv
module adapter_irq_gate #(
  parameter int NUM_CLASS = 8,
  parameter int CLASS_W   = $clog2(NUM_CLASS),
  parameter int TYPE_W    = 8,
  parameter int WORD_W    = 32,
  parameter int CLASS_LSB = 27,
  parameter int FLAG_BIT  = 31
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mode_set_i,
  input  logic [CLASS_W-1:0]         mode_class_i,
  input  logic [aig_pkg::MODE_W-1:0] mode_code_i,
  input  logic                       inj_valid_i,
  input  logic [TYPE_W-1:0]          inj_type_i,
  input  logic [CLASS_W-1:0]         inj_class_i,
  input  logic                       inj_supp_i,
  output logic                       irq_valid_o,
  output logic [WORD_W-1:0]          irq_word_o,
  output logic [TYPE_W-1:0]          irq_type_o,
  output logic                       suppressed_o,
  output logic                       mode_err_o,
  output logic [NUM_CLASS-1:0]       single_mask_o,
  output logic [NUM_CLASS-1:0]       noint_mask_o
);
  logic                 fwd, drop, err;
  logic [NUM_CLASS-1:0] arm;
  logic [WORD_W-1:0]    word;

  aig_gate #(
    .NUM_CLASS(NUM_CLASS), .CLASS_W(CLASS_W), .WORD_W(WORD_W),
    .CLASS_LSB(CLASS_LSB), .FLAG_BIT(FLAG_BIT)
  ) u_gate (
    .inj_valid_i(inj_valid_i),
    .inj_class_i(inj_class_i),
    .inj_supp_i (inj_supp_i),
    .single_i   (single_mask_o),
    .noint_i    (noint_mask_o),
    .fwd_o      (fwd),
    .drop_o     (drop),
    .arm_o      (arm),
    .word_o     (word)
  );

  aig_mode_regs #(.NUM_CLASS(NUM_CLASS), .CLASS_W(CLASS_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (mode_set_i),
    .set_class_i(mode_class_i),
    .set_code_i (mode_code_i),
    .arm_i      (arm),
    .single_o   (single_mask_o),
    .noint_o    (noint_mask_o),
    .err_o      (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o  <= 1'b0;
      irq_word_o   <= '0;
      irq_type_o   <= '0;
      suppressed_o <= 1'b0;
      mode_err_o   <= 1'b0;
    end else begin
      irq_valid_o  <= fwd;
      suppressed_o <= drop;
      mode_err_o   <= err;
      if (fwd) begin
        irq_word_o <= word;
        irq_type_o <= inj_type_i;
      end
    end
  end
endmodule

// File: rtl/aig_chk.sv
module aig_chk #(
  parameter int NUM_CLASS = 8,
  parameter int CLASS_W   = 3,
  parameter int WORD_W    = 32,
  parameter int CLASS_LSB = 27,
  parameter int FLAG_BIT  = 31
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       mode_set_i,
  input logic [CLASS_W-1:0]         mode_class_i,
  input logic [aig_pkg::MODE_W-1:0] mode_code_i,
  input logic                       inj_valid_i,
  input logic [CLASS_W-1:0]         inj_class_i,
  input logic                       inj_supp_i,
  input logic                       irq_valid_o,
  input logic [WORD_W-1:0]          irq_word_o,
  input logic                       suppressed_o,
  input logic                       mode_err_o,
  input logic [NUM_CLASS-1:0]       single_mask_o,
  input logic [NUM_CLASS-1:0]       noint_mask_o
);
  // R10
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_valid_o && suppressed_o));

  // R2
  mode_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_set_i && mode_code_i == 2'd0) |=>
      !single_mask_o[$past(mode_class_i)] && !noint_mask_o[$past(mode_class_i)]);

  // R3
  mode_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_set_i && mode_code_i == 2'd1) |=>
      single_mask_o[$past(mode_class_i)] && !noint_mask_o[$past(mode_class_i)]);

  // R4
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_set_i && mode_code_i > 2'd1 && !inj_valid_i) |=>
      mode_err_o && $stable(single_mask_o) && $stable(noint_mask_o));

  // R5
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && inj_supp_i && noint_mask_o[inj_class_i]) |=>
      suppressed_o && !irq_valid_o);

  // R6
  word_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_word_o[FLAG_BIT] &&
      (irq_word_o[CLASS_LSB-1:0] == '0));

  // R7
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && inj_supp_i && single_mask_o[inj_class_i] &&
     !noint_mask_o[inj_class_i] && !mode_set_i) |=>
      noint_mask_o[$past(inj_class_i)]);

  // R8
  plain_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && !inj_supp_i && !mode_set_i) |=>
      irq_valid_o && $stable(single_mask_o) && $stable(noint_mask_o));
endmodule

bind adapter_irq_gate aig_chk #(
  .NUM_CLASS(NUM_CLASS), .CLASS_W(CLASS_W), .WORD_W(WORD_W),
  .CLASS_LSB(CLASS_LSB), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_set_i   (mode_set_i),
  .mode_class_i (mode_class_i),
  .mode_code_i  (mode_code_i),
  .inj_valid_i  (inj_valid_i),
  .inj_class_i  (inj_class_i),
  .inj_supp_i   (inj_supp_i),
  .irq_valid_o  (irq_valid_o),
  .irq_word_o   (irq_word_o),
  .suppressed_o (suppressed_o),
  .mode_err_o   (mode_err_o),
  .single_mask_o(single_mask_o),
  .noint_mask_o (noint_mask_o)
);

// File: tb/adapter_irq_gate_tb.sv
module adapter_irq_gate_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_set_i = 1'b0;
  logic [2:0] mode_class_i = '0;
  logic [1:0] mode_code_i = '0;
  logic       inj_valid_i = 1'b0;
  logic [7:0] inj_type_i = '0;
  logic [2:0] inj_class_i = '0;
  logic       inj_supp_i = 1'b0;
  logic        irq_valid_o, suppressed_o, mode_err_o;
  logic [31:0] irq_word_o;
  logic [7:0]  irq_type_o, single_mask_o, noint_mask_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  adapter_irq_gate u_dut (.*);

  typedef struct packed {
    logic       set;
    logic [2:0] mcls;
    logic [1:0] mcode;
    logic       inj;
    logic [2:0] icls;
    logic       supp;
    logic       e_val;
    logic       e_drop;
    logic       e_err;
    logic [7:0] e_s;
    logic [7:0] e_n;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b1, 1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{1'b1,3'd3,2'd1,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b0, 8'h08,8'h00},
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b1, 1'b1,1'b0,1'b0, 8'h08,8'h08},
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b1, 1'b0,1'b1,1'b0, 8'h08,8'h08},
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b0, 1'b1,1'b0,1'b0, 8'h08,8'h08},
    '{1'b1,3'd3,2'd2,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b1, 8'h08,8'h08},
    '{1'b1,3'd3,2'd3,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b1, 8'h08,8'h08},
    '{1'b1,3'd3,2'd1,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b0, 8'h08,8'h00},
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b1, 1'b1,1'b0,1'b0, 8'h08,8'h08},
    '{1'b1,3'd5,2'd1,1'b1,3'd3,1'b1, 1'b0,1'b1,1'b0, 8'h28,8'h08},
    '{1'b0,3'd0,2'd0,1'b1,3'd5,1'b1, 1'b1,1'b0,1'b0, 8'h28,8'h28},
    '{1'b1,3'd3,2'd0,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b0, 8'h20,8'h20},
    '{1'b0,3'd0,2'd0,1'b1,3'd3,1'b1, 1'b1,1'b0,1'b0, 8'h20,8'h20},
    '{1'b1,3'd5,2'd0,1'b1,3'd5,1'b1, 1'b0,1'b1,1'b0, 8'h00,8'h00},
    '{1'b1,3'd7,2'd1,1'b1,3'd7,1'b1, 1'b1,1'b0,1'b0, 8'h80,8'h00},
    '{1'b0,3'd0,2'd0,1'b1,3'd7,1'b1, 1'b1,1'b0,1'b0, 8'h80,8'h80},
    '{1'b1,3'd0,2'd1,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b0, 8'h81,8'h80},
    '{1'b0,3'd0,2'd0,1'b1,3'd0,1'b1, 1'b1,1'b0,1'b0, 8'h81,8'h81},
    '{1'b1,3'd7,2'd1,1'b1,3'd7,1'b1, 1'b0,1'b1,1'b0, 8'h81,8'h01},
    '{1'b0,3'd0,2'd0,1'b0,3'd0,1'b0, 1'b0,1'b0,1'b0, 8'h81,8'h01},
    '{1'b1,3'd0,2'd2,1'b1,3'd0,1'b0, 1'b1,1'b0,1'b1, 8'h81,8'h01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_set_i = 1'b0; inj_valid_i = 1'b0; inj_supp_i = 1'b0;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 5000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] ew;
    logic [7:0]  et;
    repeat (3) @(negedge clk_i);
    // R1: in reset
    chk(single_mask_o == 0 && noint_mask_o == 0, "R1 masks in reset",
        {single_mask_o, noint_mask_o}, 0);
    chk(!irq_valid_o && !suppressed_o && !mode_err_o, "R1 pulses in reset",
        {irq_valid_o, suppressed_o, mode_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(single_mask_o == 0 && noint_mask_o == 0 && !irq_valid_o,
        "R1 after reset", {single_mask_o, noint_mask_o, irq_valid_o}, 0);

    for (int i = 0; i < NV; i++) begin
      mode_set_i   = VEC[i].set;
      mode_class_i = VEC[i].mcls;
      mode_code_i  = VEC[i].mcode;
      inj_valid_i  = VEC[i].inj;
      inj_class_i  = VEC[i].icls;
      inj_supp_i   = VEC[i].supp;
      inj_type_i   = 8'hA5 ^ 8'(i);
      et = inj_type_i;
      ew = {1'b1, 1'b0, VEC[i].icls, 27'd0};
      @(negedge clk_i);
      idle();
      chk(irq_valid_o == VEC[i].e_val, "R6 R8 R9 valid", irq_valid_o, VEC[i].e_val);
      chk(suppressed_o == VEC[i].e_drop, "R5 R9 dropped", suppressed_o, VEC[i].e_drop);
      chk(mode_err_o == VEC[i].e_err, "R4 error", mode_err_o, VEC[i].e_err);
      chk(single_mask_o == VEC[i].e_s, "R2 R3 R4 single mask", single_mask_o, VEC[i].e_s);
      chk(noint_mask_o == VEC[i].e_n, "R2 R3 R7 R8 R9 block mask", noint_mask_o, VEC[i].e_n);
      // R10
      chk(!(irq_valid_o && suppressed_o), "R10 exclusive",
          {irq_valid_o, suppressed_o}, 0);
      if (VEC[i].e_val) begin
        chk(irq_word_o == ew, "R6 word", irq_word_o, ew);
        chk(irq_type_o == et, "R6 type", irq_type_o, et);
      end
    end

    // R10: pulses last one cycle
    @(negedge clk_i);
    chk(!irq_valid_o && !suppressed_o && !mode_err_o, "R10 one-cycle pulses",
        {irq_valid_o, suppressed_o, mode_err_o}, 0);

    // R1: asynchronous reset mid-run clears the state
    #3 rst_ni = 1'b0;
    #2;
    chk(single_mask_o == 0 && noint_mask_o == 0, "R1 async reset",
        {single_mask_o, noint_mask_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    inj_valid_i = 1'b1; inj_class_i = 3'd0; inj_supp_i = 1'b1; inj_type_i = 8'h3C;
    @(negedge clk_i);
    idle();
    chk(irq_valid_o && irq_word_o == 32'h8000_0000, "R1 R6 forward after reset",
        irq_word_o, 32'h8000_0000);
    chk(noint_mask_o == 0, "R7 all mode no arm", noint_mask_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule